// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block gathers 32 level-sensitive interrupt inputs and drives one combined request to a primary interrupt controller. The inputs are sampled every clock into a level vector. A software-forced vector is ORed into that level vector, and an enable mask gates the result. If any gated bit is set, the combined request is raised.

A second, independent enable vector selects inputs whose level is also driven straight onto the matching line of a 32-bit passthrough output, with no regard to the mask. Only inputs 21 to 30 can ever be selected. The parent controller wires those lines to its own inputs of the same number.

Software reaches the block through a simple single-cycle 32-bit register bus. The bus uses word-aligned byte addresses. Read data and the error flag appear one cycle after the request.

Top module: `sic_passthru`

## Requirements
- R1: After reset the combined request, all passthrough lines, the read data and the error flag are zero. The level, mask, software and passthrough-enable vectors are cleared.
- R2: The combined request is high exactly when (effective level AND mask) is non-zero. The effective level is the sampled inputs ORed with the software vector. An input change shows on the output two clock edges after it is driven. A register write shows one edge after the write.
- R3: A write to word 2 (byte 0x08) ORs the write data into the mask. A write to word 3 (byte 0x0C) clears every mask bit that is written as 1. A read of word 2 returns the mask.
- R4: A write to word 4 (byte 0x10) ORs the write data into the software vector. A write to word 5 (byte 0x14) clears every software bit that is written as 1. A read of word 4 returns the software vector. Software bits act as raised inputs.
- R5: A write to word 8 (byte 0x20) sets only those passthrough-enable bits that are written as 1 and lie in positions 21 to 30 (0x7FE00000). Every other written bit is ignored. A read of word 8 returns the passthrough-enable vector.
- R6: A write to word 9 (byte 0x24) clears every passthrough-enable bit that is written as 1.
- R7: Each passthrough output bit equals the effective level of that input ANDed with its passthrough-enable bit. The mask plays no part in this.
- R8: A read of word 0 (byte 0x00) returns effective level AND mask. A read of word 1 (byte 0x04) returns the effective level.
- R9: A read of any other word, or of an address whose two low bits are not zero, returns zero and raises the error flag for one cycle. A write to such an address changes no state.
- R10: Read data and the error flag are registered. They answer the request of the previous cycle, and both are zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read |
| bus_err | output | 1 | One-cycle flag for a read of an unmapped address |
| irq_combined | output | 1 | Combined request to the primary controller |
| irq_passthru | output | 32 | Direct lines to the primary controller (bits 21 to 30 only) |

## Verification
The hardest case to reach is a passthrough line that is active while the mask blocks the same input. To check it, the passthrough output must differ from the combined request, and the software vector must also be able to raise that line. The directed part of the bench builds this case on purpose. It clears the mask, sets passthrough bits with an all-ones write, and forces bit 22 both from the pin and from the software vector. A long random phase then mixes writes, reads, misaligned and unmapped accesses with toggling inputs. A behavioural model compares every output on every clock.

// File: rtl/sic_passthru.sv
module sic_passthru #(
  parameter int          N         = 32,
  parameter int          ADDR_W    = 12,
  parameter logic [N-1:0] PT_WINDOW = 32'h7FE0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  output logic              bus_err,
  output logic              irq_combined,
  output logic [N-1:0]      irq_passthru
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] W_STATUS = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_RAW    = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_ENSET  = IDX_W'(2);
  localparam logic [IDX_W-1:0] W_ENCLR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] W_SWSET  = IDX_W'(4);
  localparam logic [IDX_W-1:0] W_SWCLR  = IDX_W'(5);
  localparam logic [IDX_W-1:0] W_PTSET  = IDX_W'(8);
  localparam logic [IDX_W-1:0] W_PTCLR  = IDX_W'(9);

  logic [N-1:0] level_q, mask_q, soft_q, pt_en_q;
  logic [N-1:0] eff, rd_val;
  logic         rd_hit, aligned, rd_req, wr_req;
  logic [IDX_W-1:0] idx;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign rd_req  = bus_sel && !bus_wr;
  assign wr_req  = bus_sel && bus_wr && aligned;
  assign eff     = level_q | soft_q;

  always_comb begin
    rd_hit = aligned;
    rd_val = '0;
    case (idx)
      W_STATUS: rd_val = eff & mask_q;
      W_RAW:    rd_val = eff;
      W_ENSET:  rd_val = mask_q;
      W_SWSET:  rd_val = soft_q;
      W_PTSET:  rd_val = pt_en_q;
      default:  rd_hit = 1'b0;
    endcase
    if (!aligned) rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      mask_q  <= '0;
      soft_q  <= '0;
      pt_en_q <= '0;
    end else begin
      level_q <= irq_in;
      if (wr_req) begin
        case (idx)
          W_ENSET: mask_q  <= mask_q | bus_wdata;
          W_ENCLR: mask_q  <= mask_q & ~bus_wdata;
          W_SWSET: soft_q  <= soft_q | bus_wdata;
          W_SWCLR: soft_q  <= soft_q & ~bus_wdata;
          W_PTSET: pt_en_q <= pt_en_q | (bus_wdata & PT_WINDOW);
          W_PTCLR: pt_en_q <= pt_en_q & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_combined <= 1'b0;
      irq_passthru <= '0;
      bus_rdata    <= '0;
      bus_err      <= 1'b0;
    end else begin
      irq_combined <= |(eff & mask_q);
      irq_passthru <= eff & pt_en_q;
      bus_rdata    <= (rd_req && rd_hit) ? rd_val : '0;
      bus_err      <= rd_req && !rd_hit;
    end
  end

  p_status_vs_comb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && aligned && idx == W_STATUS) |=> ((bus_rdata != '0) == irq_combined));

  p_mask_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx == W_ENCLR) |=> ((mask_q & $past(bus_wdata)) == '0));

  p_soft_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx == W_SWSET) |=> ((soft_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_pt_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx == W_PTSET) |=> (((pt_en_q ^ $past(pt_en_q)) & ~PT_WINDOW) == '0));

  p_pt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx == W_PTCLR) |=> ((pt_en_q & $past(bus_wdata)) == '0));

  p_bad_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_hit) |=> (bus_err && bus_rdata == '0));

  p_bad_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !aligned) |=> ($stable(mask_q) && $stable(soft_q) && $stable(pt_en_q)));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> (bus_rdata == '0 && !bus_err));
endmodule

// File: tb/sic_passthru_test.sv
module sic_passthru_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PTW = 32'h7FE0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, irq_combined;
  logic [31:0] irq_passthru;

  int checks = 0, errors = 0;
  bit model_on = 1'b0;

  sic_passthru uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_combined(irq_combined), .irq_passthru(irq_passthru)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_lvl = '0, m_mask = '0, m_soft = '0, m_pt = '0;
  logic [31:0] e_rdata = '0, e_pt = '0;
  logic        e_err = 1'b0, e_comb = 1'b0;

  always @(posedge clk) begin
    logic [31:0] eff;
    int w;
    if (!rst_n) begin
      m_lvl = '0; m_mask = '0; m_soft = '0; m_pt = '0;
      e_rdata = '0; e_err = 0; e_comb = 0; e_pt = '0;
    end else begin
      eff = m_lvl | m_soft;
      e_comb = ((eff & m_mask) != 0);
      e_pt = eff & m_pt;
      e_rdata = '0; e_err = 0;
      w = int'(bus_addr) / 4;
      if (bus_sel && !bus_wr) begin
        if (bus_addr % 4 != 0) e_err = 1;
        else if (w == 0) e_rdata = eff & m_mask;
        else if (w == 1) e_rdata = eff;
        else if (w == 2) e_rdata = m_mask;
        else if (w == 4) e_rdata = m_soft;
        else if (w == 8) e_rdata = m_pt;
        else e_err = 1;
      end
      if (bus_sel && bus_wr && bus_addr % 4 == 0) begin
        if (w == 2) m_mask = m_mask | bus_wdata;
        if (w == 3) m_mask = m_mask & ~bus_wdata;
        if (w == 4) m_soft = m_soft | bus_wdata;
        if (w == 5) m_soft = m_soft & ~bus_wdata;
        if (w == 8) m_pt = m_pt | (bus_wdata & PTW);
        if (w == 9) m_pt = m_pt & ~bus_wdata;
      end
      m_lvl = irq_in;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      check("R2 combined", {31'b0, irq_combined}, {31'b0, e_comb});
      check("R7 passthru", irq_passthru, e_pt);
      check("R10 rdata", bus_rdata, e_rdata);
      check("R9 err", {31'b0, bus_err}, {31'b0, e_err});
    end
  end

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] r, output logic e);
    bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    r = bus_rdata; e = bus_err;
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    logic e;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 comb", {31'b0, irq_combined}, 32'h0);
    check("R1 passthru", irq_passthru, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1;
    model_on = 1;
    @(negedge clk);

    // R3 mask set and R2 combined request
    access(1, 12'h008, 32'h0000_00F0, r, e);
    irq_in = 32'h0000_0010;
    idle(2);
    check("R2 comb raised", {31'b0, irq_combined}, 32'h1);
    access(0, 12'h000, '0, r, e);
    check("R8 status", r, 32'h0000_0010);
    access(0, 12'h004, '0, r, e);
    check("R8 raw", r, 32'h0000_0010);
    access(1, 12'h00C, 32'h0000_0010, r, e);
    @(negedge clk);
    check("R3 comb after clear", {31'b0, irq_combined}, 32'h0);
    access(0, 12'h008, '0, r, e);
    check("R3 mask readback", r, 32'h0000_00E0);

    // R4 software interrupts
    irq_in = '0;
    access(1, 12'h010, 32'h0000_0020, r, e);
    @(negedge clk);
    check("R4 soft raises comb", {31'b0, irq_combined}, 32'h1);
    access(0, 12'h010, '0, r, e);
    check("R4 soft readback", r, 32'h0000_0020);
    access(1, 12'h014, 32'hFFFF_FFFF, r, e);
    @(negedge clk);
    check("R4 soft cleared", {31'b0, irq_combined}, 32'h0);

    // R5 passthrough window, R7 bypasses mask
    access(1, 12'h00C, 32'hFFFF_FFFF, r, e);
    access(1, 12'h020, 32'hFFFF_FFFF, r, e);
    access(0, 12'h020, '0, r, e);
    check("R5 pt readback", r, PTW);
    irq_in = 32'h0040_0001;
    idle(2);
    check("R7 pt line with mask off", irq_passthru, 32'h0040_0000);
    check("R7 comb stays low", {31'b0, irq_combined}, 32'h0);
    irq_in = '0;
    access(1, 12'h010, 32'h0040_0000, r, e);
    @(negedge clk);
    check("R7 soft drives pt", irq_passthru, 32'h0040_0000);
    access(1, 12'h014, 32'h0040_0000, r, e);

    // R6 passthrough clear
    access(1, 12'h024, 32'h0040_0000, r, e);
    access(0, 12'h020, '0, r, e);
    check("R6 pt after clear", r, 32'h7FA0_0000);

    // R9 unmapped and misaligned
    access(0, 12'h01C, '0, r, e);
    check("R9 unmapped rdata", r, 32'h0);
    check("R9 unmapped err", {31'b0, e}, 32'h1);
    @(negedge clk);
    check("R10 err one cycle", {31'b0, bus_err}, 32'h0);
    access(1, 12'h009, 32'hFFFF_FFFF, r, e);
    access(1, 12'h030, 32'hFFFF_FFFF, r, e);
    access(0, 12'h008, '0, r, e);
    check("R9 misaligned write ignored", r, 32'h0);
    access(0, 12'h00A, '0, r, e);
    check("R9 misaligned read err", {31'b0, e}, 32'h1);

    // random phase, model compares every clock
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) irq_in = $urandom;
      if (op < 4) begin
        logic [11:0] a;
        int k;
        k = $urandom_range(0, 6);
        a = (k == 0) ? 12'h008 : (k == 1) ? 12'h00C : (k == 2) ? 12'h010 :
            (k == 3) ? 12'h014 : (k == 4) ? 12'h020 : (k == 5) ? 12'h024 :
            12'($urandom_range(0, 63));
        access(1, a, $urandom & $urandom, r, e);
      end else if (op < 8) begin
        access(0, 12'($urandom_range(0, 12) * 4 + (($urandom_range(0, 7) == 0) ? 1 : 0)), '0, r, e);
      end else begin
        @(negedge clk);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule